// File: doc/BRIEF.md
# Display Status and Interrupt Unit

This unit gathers the error and state events of a display controller that drives one panel or two panels at once, and turns them into sticky status flags and a single interrupt request. Event pulses come from the pixel fetch DMA, from the input and output FIFOs of the panel pipelines and from the controller enable. Each one sets a status flag that stays set until software writes a one to its position.

Each flag class has a mask bit, and the unit raises its combined interrupt while any set flag is unmasked. The unit also handles two pieces of control. The first is the orderly stop after the controller is switched off: it waits for the current fetch burst to finish, then stops the controller and releases the panel pins. The second is the fetch halt after a bus error, which holds until the descriptor addresses have been written again.

Top module: `disp_stat_irq`

## Requirements
- R1: After reset every status flag, `irq`, `stop_now` and `dma_halt` are 0.
- R2: A pulse on `out_empty_rd` sets status bit 1 (output underrun) at the next clock edge. The bit stays set until it is cleared by software.
- R3: A pulse on `up_empty_rd` sets status bit 2 (upper input underrun) in both single-panel mode (`dual_mode`=0) and dual-panel mode.
- R4: A pulse on `lo_empty_rd` sets status bit 3 (lower input underrun) only when `dual_mode`=1. In single-panel mode the pulse leaves the bit unchanged.
- R5: A cycle with `clr_wr`=1 clears exactly the status bits whose positions in `clr_data` are 1. A zero in `clr_data` leaves its bit unchanged.
- R6: If a set event and a clear of the same bit happen in the same cycle, the bit ends the cycle set.
- R7: `irq` is 1 exactly when at least one status bit is set and its mask is 0. The mask bits are: `mask`[0] for bit 0, `mask`[1] for bit 1, `mask`[2] shared by bits 2 and 3, and `mask`[3] for bit 4.
- R8: Status bit 0 (quick stop) sets only after `ctrl_en` falls, and only at the first clock edge at which `burst_busy` is 0 with `ctrl_en` still 0. While `burst_busy` is 1 the bit stays clear.
- R9: `stop_now` rises together with status bit 0. It stays 1 until `ctrl_en` is 1 at a clock edge.
- R10: A pulse on `bus_err` sets status bit 4 and raises `dma_halt`. In single-panel mode a write to descriptor 0 (`desc_wr`[0]) releases the halt, and a write to descriptor 1 alone does not.
- R11: In dual-panel mode a bus error halts both channels. `dma_halt` falls only after both `desc_wr`[0] and `desc_wr`[1] have been seen, in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dual_mode | input | 1 | 1 = two panels driven together |
| ctrl_en | input | 1 | Controller enable |
| burst_busy | input | 1 | Fetch DMA burst in progress |
| out_empty_rd | input | 1 | Pin driver read an empty output FIFO |
| up_empty_rd | input | 1 | Unpacker read the empty upper input FIFO |
| lo_empty_rd | input | 1 | Unpacker read the empty lower input FIFO |
| bus_err | input | 1 | Fetch transfer hit a bus error |
| desc_wr | input | 2 | Descriptor address written, per channel |
| clr_wr | input | 1 | Status clear strobe |
| clr_data | input | 5 | Write-one-to-clear pattern |
| mask | input | 4 | Interrupt masks, 1 = masked |
| status | output | 5 | Sticky status flags |
| irq | output | 1 | Combined interrupt request |
| stop_now | output | 1 | Controller stopped, panel pins released |
| dma_halt | output | 1 | Fetch halted after bus error |

## Verification
The underrun events are tried in both panel modes. This shows apart a lower-panel flag that is correctly qualified by the mode from one that always sets. Clears are applied with patterns that hit other bits, the target bit, and the target bit in the same cycle as its event, which separates a clean write-one-to-clear from one that clears too much or loses events. The disable is tried with the burst busy for several cycles and then idle, and the bus error with descriptor writes in both orders in each mode. Every cycle is compared against a behavioural model, with mask patterns that include the shared input-underrun mask.

// File: rtl/disp_stat_pkg.sv
package disp_stat_pkg;
  localparam int ST_QD  = 0;
  localparam int ST_OU  = 1;
  localparam int ST_IUU = 2;
  localparam int ST_IUL = 3;
  localparam int ST_BER = 4;
  localparam int NUM_ST = 5;

  localparam int MK_QD  = 0;
  localparam int MK_OU  = 1;
  localparam int MK_IU  = 2;
  localparam int MK_BER = 3;
  localparam int NUM_MK = 4;

  localparam int NUM_CH = 2;

  // Spread the per-class masks over the status positions
  function automatic logic [NUM_ST-1:0] mask_spread(input logic [NUM_MK-1:0] m);
    logic [NUM_ST-1:0] r;
    r[ST_QD]  = m[MK_QD];
    r[ST_OU]  = m[MK_OU];
    r[ST_IUU] = m[MK_IU];
    r[ST_IUL] = m[MK_IU];
    r[ST_BER] = m[MK_BER];
    return r;
  endfunction

  function automatic logic any_pending(input logic [NUM_ST-1:0] st,
                                       input logic [NUM_MK-1:0] m);
    return |(st & ~mask_spread(m));
  endfunction
endpackage

// File: rtl/disp_sticky_bits.sv
module disp_sticky_bits #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_ev,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q[i] <= 1'b0;
      else if (set_ev[i])
        q[i] <= 1'b1;
      else if (clr_wr && clr_data[i])
        q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_qd_seq.sv
module disp_qd_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_en,
  input  logic burst_busy,
  output logic qd_ev,
  output logic stop_now
);
  logic en_q;
  logic pend_q;
  logic en_fall;
  logic armed;

  assign en_fall = en_q && !ctrl_en;
  assign armed   = en_fall || pend_q;
  assign qd_ev   = armed && !burst_busy && !ctrl_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
      stop_now <= 1'b0;
    end else begin
      en_q   <= ctrl_en;
      pend_q <= armed && !qd_ev && !ctrl_en;
      if (qd_ev)
        stop_now <= 1'b1;
      else if (ctrl_en)
        stop_now <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_dma_halt.sv
module disp_dma_halt #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           dual_mode,
  input  logic           bus_err,
  input  logic [NCH-1:0] desc_wr,
  output logic [NCH-1:0] ch_halt
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    if (c == 0) begin : g_primary
      assign hit = bus_err;
    end else begin : g_secondary
      assign hit = bus_err && dual_mode;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ch_halt[c] <= 1'b0;
      else if (hit)
        ch_halt[c] <= 1'b1;
      else if (desc_wr[c])
        ch_halt[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_stat_irq.sv
module disp_stat_irq
  import disp_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dual_mode,
  input  logic              ctrl_en,
  input  logic              burst_busy,
  input  logic              out_empty_rd,
  input  logic              up_empty_rd,
  input  logic              lo_empty_rd,
  input  logic              bus_err,
  input  logic [NUM_CH-1:0] desc_wr,
  input  logic              clr_wr,
  input  logic [NUM_ST-1:0] clr_data,
  input  logic [NUM_MK-1:0] mask,
  output logic [NUM_ST-1:0] status,
  output logic              irq,
  output logic              stop_now,
  output logic              dma_halt
);
  logic              qd_ev;
  logic              lo_qual;
  logic [NUM_ST-1:0] set_vec;
  logic [NUM_CH-1:0] ch_halt;

  assign lo_qual = lo_empty_rd && dual_mode;

  always_comb begin
    set_vec         = '0;
    set_vec[ST_QD]  = qd_ev;
    set_vec[ST_OU]  = out_empty_rd;
    set_vec[ST_IUU] = up_empty_rd;
    set_vec[ST_IUL] = lo_qual;
    set_vec[ST_BER] = bus_err;
  end

  disp_qd_seq u_qd (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_en    (ctrl_en),
    .burst_busy (burst_busy),
    .qd_ev      (qd_ev),
    .stop_now   (stop_now)
  );

  disp_sticky_bits #(.W(NUM_ST)) u_st (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_ev   (set_vec),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .q        (status)
  );

  disp_dma_halt #(.NCH(NUM_CH)) u_halt (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual_mode (dual_mode),
    .bus_err   (bus_err),
    .desc_wr   (desc_wr),
    .ch_halt   (ch_halt)
  );

  assign dma_halt = |ch_halt;
  assign irq      = any_pending(status, mask);
endmodule

// File: rtl/disp_stat_irq_chk.sv
module disp_stat_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dual_mode,
  input logic       ctrl_en,
  input logic       burst_busy,
  input logic       out_empty_rd,
  input logic       lo_empty_rd,
  input logic       bus_err,
  input logic       clr_wr,
  input logic [4:0] clr_data,
  input logic [3:0] mask,
  input logic [4:0] status,
  input logic       irq,
  input logic       stop_now,
  input logic       dma_halt,
  input logic       qd_ev
);
  logic [4:0] keep;
  assign keep = clr_wr ? ~clr_data : 5'h1f;

  p_ou_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_empty_rd |=> status[1]);

  p_iul_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && !status[3]) |=> !status[3]);

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(status & keep)) == $past(status & keep)));

  p_irq_ou_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !mask[1]) |-> irq);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 5'b0) |-> !irq);

  p_qd_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[0] && burst_busy) |=> !status[0]);

  p_qd_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    qd_ev |-> (!ctrl_en && !burst_busy));

  p_stop_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_now) |-> status[0]);

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_now && !ctrl_en) |=> stop_now);

  p_halt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (dma_halt && status[4]));
endmodule

bind disp_stat_irq disp_stat_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dual_mode    (dual_mode),
  .ctrl_en      (ctrl_en),
  .burst_busy   (burst_busy),
  .out_empty_rd (out_empty_rd),
  .lo_empty_rd  (lo_empty_rd),
  .bus_err      (bus_err),
  .clr_wr       (clr_wr),
  .clr_data     (clr_data),
  .mask         (mask),
  .status       (status),
  .irq          (irq),
  .stop_now     (stop_now),
  .dma_halt     (dma_halt),
  .qd_ev        (qd_ev)
);

// File: tb/disp_stat_irq_test.sv
module disp_stat_irq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dual_mode = 1'b0;
  logic       ctrl_en = 1'b0;
  logic       burst_busy = 1'b0;
  logic       out_empty_rd = 1'b0;
  logic       up_empty_rd = 1'b0;
  logic       lo_empty_rd = 1'b0;
  logic       bus_err = 1'b0;
  logic [1:0] desc_wr = 2'b0;
  logic       clr_wr = 1'b0;
  logic [4:0] clr_data = 5'b0;
  logic [3:0] mask = 4'b0;
  logic [4:0] status;
  logic       irq;
  logic       stop_now;
  logic       dma_halt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  disp_stat_irq uut (
    .clk(clk), .rst_n(rst_n), .dual_mode(dual_mode), .ctrl_en(ctrl_en),
    .burst_busy(burst_busy), .out_empty_rd(out_empty_rd),
    .up_empty_rd(up_empty_rd), .lo_empty_rd(lo_empty_rd), .bus_err(bus_err),
    .desc_wr(desc_wr), .clr_wr(clr_wr), .clr_data(clr_data), .mask(mask),
    .status(status), .irq(irq), .stop_now(stop_now), .dma_halt(dma_halt)
  );

  // Behavioural reference
  bit [4:0] m_st;
  bit m_enq, m_pend, m_stop, m_h0, m_h1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_enq = 0; m_pend = 0; m_stop = 0; m_h0 = 0; m_h1 = 0;
    end else begin
      bit waiting, fire;
      waiting = (m_enq && !ctrl_en) || m_pend;
      fire = waiting && !burst_busy && !ctrl_en;
      if (clr_wr) m_st = m_st & ~clr_data;
      if (fire) m_st[0] = 1;
      if (out_empty_rd) m_st[1] = 1;
      if (up_empty_rd) m_st[2] = 1;
      if (lo_empty_rd && dual_mode) m_st[3] = 1;
      if (bus_err) m_st[4] = 1;
      m_pend = waiting && !fire && !ctrl_en;
      if (fire) m_stop = 1; else if (ctrl_en) m_stop = 0;
      if (desc_wr[0]) m_h0 = 0;
      if (desc_wr[1]) m_h1 = 0;
      if (bus_err) begin m_h0 = 1; if (dual_mode) m_h1 = 1; end
      m_enq = ctrl_en;
    end
  end

  function automatic bit model_irq();
    return (m_st[0] && !mask[0]) || (m_st[1] && !mask[1]) ||
           ((m_st[2] || m_st[3]) && !mask[2]) || (m_st[4] && !mask[3]);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      check(status[0] == m_st[0], "R8 quick-stop flag", status[0], m_st[0]);
      check(status[1] == m_st[1], "R2 output underrun flag", status[1], m_st[1]);
      check(status[2] == m_st[2], "R3 upper underrun flag", status[2], m_st[2]);
      check(status[3] == m_st[3], "R4 lower underrun flag", status[3], m_st[3]);
      check(status[4] == m_st[4], "R10 bus error flag", status[4], m_st[4]);
      check(irq == model_irq(), "R7 irq", irq, model_irq());
      check(stop_now == m_stop, "R9 stop_now", stop_now, m_stop);
      check(dma_halt == (m_h0 || m_h1), "R11 dma_halt", dma_halt, m_h0 || m_h1);
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear(input logic [4:0] pat);
    clr_wr = 1; clr_data = pat; tick(); clr_wr = 0; clr_data = 0;
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    // R1
    check(status == 0 && !irq && !stop_now && !dma_halt, "R1 reset state",
          {status, irq, stop_now, dma_halt}, 0);

    // R2 output underrun, sticky
    out_empty_rd = 1; tick(); out_empty_rd = 0;
    check(status[1] == 1, "R2 ou set", status[1], 1);
    check(irq == 1, "R7 irq from ou", irq, 1);
    tick(3);
    check(status[1] == 1, "R2 ou sticky", status[1], 1);
    // R5 clear other bits only
    clear(5'b11101);
    check(status == 5'b00010, "R5 zero in pattern keeps bit", status, 5'b00010);
    clear(5'b00010);
    check(status == 0 && !irq, "R5 ou cleared", status, 0);

    // R3 and R4 in single-panel mode
    up_empty_rd = 1; lo_empty_rd = 1; tick(); up_empty_rd = 0; lo_empty_rd = 0;
    check(status[2] == 1, "R3 upper set single", status[2], 1);
    check(status[3] == 0, "R4 lower ignored single", status[3], 0);
    clear(5'b00100);
    // dual-panel mode
    dual_mode = 1;
    up_empty_rd = 1; tick(); up_empty_rd = 0;
    lo_empty_rd = 1; tick(); lo_empty_rd = 0;
    check(status[3:2] == 2'b11, "R4 lower set dual / R3 upper dual", status[3:2], 3);
    // R7 shared mask
    mask = 4'b0100; tick();
    check(irq == 0, "R7 shared mask hides both", irq, 0);
    clear(5'b00100);
    check(irq == 0, "R7 lower still masked", irq, 0);
    mask = 4'b0000; tick();
    check(irq == 1, "R7 lower unmasked", irq, 1);
    clear(5'b01000);
    mask = 4'b1101; tick();

    // R6 set wins over clear
    out_empty_rd = 1; clr_wr = 1; tick(); clr_wr = 0; out_empty_rd = 0;
    tick();
    out_empty_rd = 1; clr_wr = 1; clr_data = 5'b00010; tick();
    out_empty_rd = 0; clr_wr = 0; clr_data = 0;
    check(status[1] == 1, "R6 set wins", status[1], 1);
    check(irq == 1, "R7 ou unmasked with others masked", irq, 1);
    clear(5'b00010);
    mask = 4'b0000;

    // R8 / R9 quick stop
    ctrl_en = 1; tick(3);
    burst_busy = 1; ctrl_en = 0; tick(4);
    check(status[0] == 0 && !stop_now, "R8 waits for burst", status[0], 0);
    burst_busy = 0; tick();
    check(status[0] == 1, "R8 quick stop set", status[0], 1);
    check(stop_now == 1, "R9 stop asserted", stop_now, 1);
    clear(5'b00001); tick(2);
    check(stop_now == 1, "R9 stop held while disabled", stop_now, 1);
    ctrl_en = 1; tick();
    check(stop_now == 0, "R9 stop released on enable", stop_now, 0);
    // enable drop with idle burst: sets at once
    ctrl_en = 0; tick();
    check(status[0] == 1, "R8 immediate when idle", status[0], 1);
    ctrl_en = 1; clear(5'b00001); tick();

    // R10 single-mode bus error
    dual_mode = 0;
    bus_err = 1; tick(); bus_err = 0;
    check(dma_halt && status[4], "R10 halt on bus error", {dma_halt, status[4]}, 3);
    desc_wr = 2'b10; tick(); desc_wr = 0;
    check(dma_halt == 1, "R10 ch1 write no release", dma_halt, 1);
    desc_wr = 2'b01; tick(); desc_wr = 0;
    check(dma_halt == 0, "R10 ch0 write releases", dma_halt, 0);
    check(status[4] == 1, "R10 flag stays", status[4], 1);
    clear(5'b10000);

    // R11 dual mode, both orders
    dual_mode = 1;
    bus_err = 1; tick(); bus_err = 0;
    desc_wr = 2'b01; tick(); desc_wr = 0;
    check(dma_halt == 1, "R11 one write not enough", dma_halt, 1);
    desc_wr = 2'b10; tick(); desc_wr = 0;
    check(dma_halt == 0, "R11 both written", dma_halt, 0);
    bus_err = 1; tick(); bus_err = 0;
    desc_wr = 2'b10; tick(); desc_wr = 0;
    check(dma_halt == 1, "R11 reverse order one write", dma_halt, 1);
    desc_wr = 2'b01; tick(); desc_wr = 0;
    check(dma_halt == 0, "R11 reverse order both", dma_halt, 0);
    clear(5'b11111);
    tick(2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule